// File: doc/BRIEF.md
# Marker Collision Inversion Table

A memory controller that stores compressed lines tags each compressed slot with an in-line marker word in the slot's last four bytes, and there are two marker values: one for two-to-one packing and one for four-to-one packing. An ordinary uncompressed line could happen to end in one of those words. A later read would then treat it as compressed and corrupt it. This block closes that gap. It sits on the write-back path and on the read-return path.

On the write path, every uncompressed line has its tail word (the most significant 32 bits of the line) compared with both configured markers. On a match, the block sends the line to memory with every bit inverted and records the line address in a small fully associative table. On the read path, returning data whose address is in the table is inverted again, which restores the value that was originally written. Later writes to a tracked address keep or release its entry, depending on whether the new data still collides. If a collision cannot be tracked because the table is full, the outgoing beat is flagged, so the controller can record the address somewhere else.

Top module: `collide_guard`

## Requirements
- R1: An uncompressed write whose tail word (bits LINE_W-1 down to LINE_W-32) equals either marker is emitted with every bit inverted. Any other uncompressed write is emitted unchanged.
- R2: A write flagged compressed is emitted unchanged, and no marker check is applied to it.
- R3: A colliding uncompressed write to an untracked address, made while the table has a free entry, adds that address and raises the occupancy count by one.
- R4: A colliding uncompressed write to an address already tracked leaves exactly one entry for it, and the occupancy count does not change.
- R5: A non-colliding write or a compressed write to a tracked address removes its entry and lowers the count by one. Later reads of that address return data uninverted.
- R6: A read of a tracked address returns the memory data inverted, with the flip flag set to 1. A read of an untracked address returns the data unchanged, with the flip flag set to 0.
- R7: The table holds DEPTH entries (16 by default). The full output is 1 exactly when the count equals DEPTH, and the count never exceeds DEPTH.
- R8: A colliding write to an untracked address while the table is full is still emitted inverted, with its spill flag set to 1. The table and the count stay unchanged.
- R9: Each path has one register stage. An accepted beat appears on the next cycle and holds stable while its output ready is low. An input is ready when its output stage is empty or being drained.
- R10: A read accepted in the same cycle as a write looks up the table as it stood before that write's update.
- R11: After reset the table is empty, the count is 0, full is 0, and neither output is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mark2 | input | MARK_W | Marker word for two-to-one slots |
| cfg_mark4 | input | MARK_W | Marker word for four-to-one slots |
| wr_valid | input | 1 | Write-back beat valid |
| wr_ready | output | 1 | Write-back beat accepted |
| wr_addr | input | ADDR_W | Line address of the write |
| wr_data | input | LINE_W | Line data of the write |
| wr_comp | input | 1 | Line is already compressed and carries a marker |
| wo_valid | output | 1 | Beat to memory valid |
| wo_ready | input | 1 | Memory side takes the beat |
| wo_addr | output | ADDR_W | Address of the beat to memory |
| wo_data | output | LINE_W | Data to memory, inverted on collision |
| wo_comp | output | 1 | Compressed flag passed through |
| wo_spill | output | 1 | Inverted line could not be tracked |
| rd_valid | input | 1 | Read return beat valid |
| rd_ready | output | 1 | Read return beat accepted |
| rd_addr | input | ADDR_W | Address of the returned line |
| rd_data | input | LINE_W | Line data as read from memory |
| ro_valid | output | 1 | Restored read beat valid |
| ro_ready | input | 1 | Consumer takes the read beat |
| ro_addr | output | ADDR_W | Address of the restored beat |
| ro_data | output | LINE_W | Restored line data |
| ro_flip | output | 1 | Line was inverted back |
| tbl_count | output | $clog2(DEPTH+1) | Number of valid table entries |
| tbl_full | output | 1 | Table has no free entry |

## Verification
The bench fills the table one entry at a time, alternating between the two markers, and then reads every tracked address and an untracked one. A design with a wrong compare or a lost entry would return a line still inverted, or fail to invert one. It then tries a new collision while the table is full. A design that overwrote an entry there would lose a tracked address and corrupt a later read. It rewrites a tracked address with colliding data, and a design that allocated again would show the count climbing. It releases entries through both plain and compressed writes, and a design that missed the compressed case would invert compressed data on readback. A read and a write to the same address in one cycle check that the lookup uses the table from before that cycle's update. A stalled output checks that the beat does not change while it waits.

// File: rtl/cg_pkg.sv
package cg_pkg;

    // What a single accepted write does to the table and the outgoing beat.
    typedef enum logic [2:0] {
        WA_PASS,        // no collision, address untracked
        WA_FLIP_HOLD,   // collision on a tracked address: keep its entry
        WA_FLIP_ADD,    // collision on a new address: allocate
        WA_FLIP_SPILL,  // collision on a new address, table full
        WA_PASS_DROP    // no collision on a tracked address: release
    } wr_act_e;

endpackage

// File: rtl/cg_match.sv
module cg_match #(
    parameter int LINE_W = 512,
    parameter int MARK_W = 32
) (
    input  logic [LINE_W-1:0] line_i,
    input  logic [MARK_W-1:0] mark_a_i,
    input  logic [MARK_W-1:0] mark_b_i,
    output logic              hit_o
);
    localparam int TAIL_HI = LINE_W - 1;

    logic [MARK_W-1:0] tail;

    assign tail  = line_i[TAIL_HI -: MARK_W];
    assign hit_o = (tail == mark_a_i) || (tail == mark_b_i);

endmodule

// File: rtl/cg_lookup.sv
module cg_lookup #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]             ent_valid_i,
    input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr_i,
    input  logic [ADDR_W-1:0]            key_i,
    output logic                         hit_o,
    output logic [IDX_W-1:0]             idx_o
);
    logic [DEPTH-1:0] match;

    // One comparator per entry, all in parallel.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = ent_valid_i[g] && (ent_addr_i[g] == key_i);
    end

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) idx_o = IDX_W'(i);
        end
    end

    assign hit_o = |match;

endmodule

// File: rtl/cg_table.sv
module cg_table #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ins_en_i,
    input  logic [IDX_W-1:0]             ins_idx_i,
    input  logic [ADDR_W-1:0]            ins_addr_i,
    input  logic                         del_en_i,
    input  logic [IDX_W-1:0]             del_idx_i,
    output logic [DEPTH-1:0]             ent_valid_o,
    output logic [DEPTH-1:0][ADDR_W-1:0] ent_addr_o,
    output logic [IDX_W-1:0]             free_idx_o,
    output logic [CNT_W-1:0]             count_o,
    output logic                         full_o
);
    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][ADDR_W-1:0] adr;
        logic [CNT_W-1:0]             cnt;
    } tab_t;

    tab_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (ins_en_i) begin
            t_d.vld[ins_idx_i] = 1'b1;
            t_d.adr[ins_idx_i] = ins_addr_i;
            t_d.cnt            = t_q.cnt + 1'b1;
        end else if (del_en_i) begin
            t_d.vld[del_idx_i] = 1'b0;
            t_d.cnt            = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // Lowest free slot; meaningless while full.
    always_comb begin
        free_idx_o = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!t_q.vld[i]) free_idx_o = IDX_W'(i);
        end
    end

    assign ent_valid_o = t_q.vld;
    assign ent_addr_o  = t_q.adr;
    assign count_o     = t_q.cnt;
    assign full_o      = (t_q.cnt == CNT_W'(DEPTH));

endmodule

// File: rtl/collide_guard.sv
module collide_guard
    import cg_pkg::*;
#(
    parameter int LINE_W = 512,
    parameter int ADDR_W = 32,
    parameter int MARK_W = 32,
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MARK_W-1:0] cfg_mark2,
    input  logic [MARK_W-1:0] cfg_mark4,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LINE_W-1:0] wr_data,
    input  logic              wr_comp,
    output logic              wo_valid,
    input  logic              wo_ready,
    output logic [ADDR_W-1:0] wo_addr,
    output logic [LINE_W-1:0] wo_data,
    output logic              wo_comp,
    output logic              wo_spill,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [LINE_W-1:0] rd_data,
    output logic              ro_valid,
    input  logic              ro_ready,
    output logic [ADDR_W-1:0] ro_addr,
    output logic [LINE_W-1:0] ro_data,
    output logic              ro_flip,
    output logic [CNT_W-1:0]  tbl_count,
    output logic              tbl_full
);
    typedef struct packed {
        logic              wo_vld;
        logic [ADDR_W-1:0] wo_adr;
        logic [LINE_W-1:0] wo_dat;
        logic              wo_cmp;
        logic              wo_spl;
        logic              ro_vld;
        logic [ADDR_W-1:0] ro_adr;
        logic [LINE_W-1:0] ro_dat;
        logic              ro_flp;
    } stage_t;

    stage_t s_d, s_q;

    logic [DEPTH-1:0]             ent_valid;
    logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
    logic [IDX_W-1:0]             free_idx;
    logic                         full;
    logic                         mark_hit;
    logic                         w_hit, r_hit;
    logic [IDX_W-1:0]             w_idx, r_idx;
    logic                         wr_fire, rd_fire;
    logic                         ins_en, del_en;
    wr_act_e                      act;

    cg_match #(.LINE_W(LINE_W), .MARK_W(MARK_W)) u_match (
        .line_i   (wr_data),
        .mark_a_i (cfg_mark2),
        .mark_b_i (cfg_mark4),
        .hit_o    (mark_hit)
    );

    cg_lookup #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_wlook (
        .ent_valid_i (ent_valid),
        .ent_addr_i  (ent_addr),
        .key_i       (wr_addr),
        .hit_o       (w_hit),
        .idx_o       (w_idx)
    );

    cg_lookup #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_rlook (
        .ent_valid_i (ent_valid),
        .ent_addr_i  (ent_addr),
        .key_i       (rd_addr),
        .hit_o       (r_hit),
        .idx_o       (r_idx)
    );

    cg_table #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .ins_en_i    (ins_en),
        .ins_idx_i   (free_idx),
        .ins_addr_i  (wr_addr),
        .del_en_i    (del_en),
        .del_idx_i   (w_idx),
        .ent_valid_o (ent_valid),
        .ent_addr_o  (ent_addr),
        .free_idx_o  (free_idx),
        .count_o     (tbl_count),
        .full_o      (full)
    );

    assign wr_ready = !s_q.wo_vld || wo_ready;
    assign rd_ready = !s_q.ro_vld || ro_ready;
    assign wr_fire  = wr_valid && wr_ready;
    assign rd_fire  = rd_valid && rd_ready;

    // Write decision.
    always_comb begin
        act = WA_PASS;
        if (!wr_comp && mark_hit) begin
            if (w_hit)      act = WA_FLIP_HOLD;
            else if (!full) act = WA_FLIP_ADD;
            else            act = WA_FLIP_SPILL;
        end else if (w_hit) begin
            act = WA_PASS_DROP;
        end
    end

    assign ins_en = wr_fire && (act == WA_FLIP_ADD);
    assign del_en = wr_fire && (act == WA_PASS_DROP);

    always_comb begin
        s_d = s_q;
        if (wo_ready) s_d.wo_vld = 1'b0;
        if (ro_ready) s_d.ro_vld = 1'b0;
        if (wr_fire) begin
            s_d.wo_vld = 1'b1;
            s_d.wo_adr = wr_addr;
            s_d.wo_cmp = wr_comp;
            s_d.wo_spl = (act == WA_FLIP_SPILL);
            unique case (act)
                WA_FLIP_HOLD, WA_FLIP_ADD, WA_FLIP_SPILL: s_d.wo_dat = ~wr_data;
                default:                                  s_d.wo_dat = wr_data;
            endcase
        end
        if (rd_fire) begin
            s_d.ro_vld = 1'b1;
            s_d.ro_adr = rd_addr;
            s_d.ro_flp = r_hit;
            s_d.ro_dat = r_hit ? ~rd_data : rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wo_valid = s_q.wo_vld;
    assign wo_addr  = s_q.wo_adr;
    assign wo_data  = s_q.wo_dat;
    assign wo_comp  = s_q.wo_cmp;
    assign wo_spill = s_q.wo_spl;
    assign ro_valid = s_q.ro_vld;
    assign ro_addr  = s_q.ro_adr;
    assign ro_data  = s_q.ro_dat;
    assign ro_flip  = s_q.ro_flp;
    assign tbl_full = full;

endmodule

// File: rtl/cg_checker.sv
module cg_checker #(
    parameter int LINE_W = 512,
    parameter int MARK_W = 32,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MARK_W-1:0] cfg_mark2,
    input logic [MARK_W-1:0] cfg_mark4,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [LINE_W-1:0] wr_data,
    input logic              wr_comp,
    input logic              wr_hit,
    input logic              wo_valid,
    input logic              wo_ready,
    input logic [LINE_W-1:0] wo_data,
    input logic              wo_comp,
    input logic              wo_spill,
    input logic              ro_valid,
    input logic              ro_ready,
    input logic [LINE_W-1:0] ro_data,
    input logic [CNT_W-1:0]  tbl_count,
    input logic              tbl_full
);
    logic [MARK_W-1:0] out_tail, in_tail;
    logic              in_coll;

    assign out_tail = wo_data[LINE_W-1 -: MARK_W];
    assign in_tail  = wr_data[LINE_W-1 -: MARK_W];
    assign in_coll  = !wr_comp && ((in_tail == cfg_mark2) || (in_tail == cfg_mark4));

    // R1: stored uncompressed data never carries a marker tail.
    p_tail_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wo_valid && !wo_comp && (cfg_mark4 != ~cfg_mark2)) |->
        ((out_tail != cfg_mark2) && (out_tail != cfg_mark4)));

    // R4: a colliding rewrite of a tracked address allocates nothing.
    p_no_dup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && in_coll && wr_hit) |=> $stable(tbl_count));

    // R5: a clean rewrite of a tracked address frees one entry.
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && !in_coll && wr_hit) |=>
        (tbl_count == $past(tbl_count) - 1'b1));

    // R7: occupancy bounded.
    p_count_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_count <= CNT_W'(DEPTH));

    // R8: spill only when the table is full.
    p_spill_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wo_valid && wo_spill) |-> tbl_full);

    // R9: stalled beats hold.
    p_wo_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wo_valid && !wo_ready) |=> (wo_valid && $stable(wo_data)));

    p_ro_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ro_valid && !ro_ready) |=> (ro_valid && $stable(ro_data)));

endmodule

bind collide_guard cg_checker #(
    .LINE_W (LINE_W),
    .MARK_W (MARK_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
) u_cg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mark2 (cfg_mark2),
    .cfg_mark4 (cfg_mark4),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_data   (wr_data),
    .wr_comp   (wr_comp),
    .wr_hit    (w_hit),
    .wo_valid  (wo_valid),
    .wo_ready  (wo_ready),
    .wo_data   (wo_data),
    .wo_comp   (wo_comp),
    .wo_spill  (wo_spill),
    .ro_valid  (ro_valid),
    .ro_ready  (ro_ready),
    .ro_data   (ro_data),
    .tbl_count (tbl_count),
    .tbl_full  (tbl_full)
);

// File: tb/test_collide_guard.sv
module test_collide_guard;
    localparam int LW = 64;
    localparam int AW = 8;
    localparam int MW = 32;
    localparam int DP = 16;
    localparam int CW = $clog2(DP + 1);
    localparam logic [MW-1:0] M2 = 32'h5EED_C0DE;
    localparam logic [MW-1:0] M4 = 32'hB16B_00B5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0, wr_comp = 1'b0, wo_ready = 1'b1;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [LW-1:0] wr_data = '0, rd_data = '0;
    logic          rd_valid = 1'b0, ro_ready = 1'b1;
    logic          wr_ready, rd_ready, wo_valid, wo_comp, wo_spill, ro_valid, ro_flip, tbl_full;
    logic [AW-1:0] wo_addr, ro_addr;
    logic [LW-1:0] wo_data, ro_data;
    logic [CW-1:0] tbl_count;

    int nchk = 0, nerr = 0, cnt = 0;
    bit tracked [256];

    always #2 clk = ~clk;

    collide_guard #(.LINE_W(LW), .ADDR_W(AW), .MARK_W(MW), .DEPTH(DP)) i_collide_guard (
        .clk(clk), .rst_n(rst_n), .cfg_mark2(M2), .cfg_mark4(M4),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_comp(wr_comp), .wo_valid(wo_valid), .wo_ready(wo_ready), .wo_addr(wo_addr),
        .wo_data(wo_data), .wo_comp(wo_comp), .wo_spill(wo_spill),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
        .ro_valid(ro_valid), .ro_ready(ro_ready), .ro_addr(ro_addr), .ro_data(ro_data),
        .ro_flip(ro_flip), .tbl_count(tbl_count), .tbl_full(tbl_full)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] mk(input int kind, input int seed);
        logic [31:0] lo = 32'h1234_0000 ^ 32'(seed * 32'h9E37);
        case (kind)
            1:       return {M2, lo};
            2:       return {M4, lo};
            default: return {32'h0F0F_0000 ^ 32'(seed), lo};
        endcase
    endfunction

    // Apply model update for a write; returns expected data and spill.
    task automatic model_write(input logic [AW-1:0] a, input logic [LW-1:0] d, input bit c,
                               output logic [LW-1:0] ed, output bit esp);
        bit coll = !c && ((d[LW-1 -: MW] == M2) || (d[LW-1 -: MW] == M4));
        ed  = coll ? ~d : d;
        esp = 1'b0;
        if (coll) begin
            if (!tracked[a]) begin
                if (cnt < DP) begin tracked[a] = 1'b1; cnt++; end
                else esp = 1'b1;
            end
        end else if (tracked[a]) begin
            tracked[a] = 1'b0; cnt--;
        end
    endtask

    task automatic do_write(input string req, input logic [AW-1:0] a,
                            input logic [LW-1:0] d, input bit c);
        logic [LW-1:0] ed; bit esp;
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_comp = c;
        model_write(a, d, c, ed, esp);
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        chk(wo_valid == 1'b1, req, "wo_valid", LW'(wo_valid), 1);
        chk(wo_data == ed, req, "wo_data", wo_data, ed);
        chk(wo_spill == esp, req, "wo_spill", LW'(wo_spill), LW'(esp));
        chk(int'(tbl_count) == cnt, req, "tbl_count", LW'(tbl_count), LW'(cnt));
        chk(tbl_full == (cnt == DP), req, "tbl_full", LW'(tbl_full), LW'(cnt == DP));
    endtask

    task automatic do_read(input string req, input logic [AW-1:0] a, input logic [LW-1:0] d);
        bit ef = tracked[a];
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = a; rd_data = d;
        @(posedge clk);
        @(negedge clk);
        rd_valid = 1'b0;
        chk(ro_valid && ro_flip == ef, req, "ro_flip", LW'(ro_flip), LW'(ef));
        chk(ro_data == (ef ? ~d : d), req, "ro_data", ro_data, ef ? ~d : d);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [LW-1:0] ed, da, db; bit esp;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!wo_valid && !ro_valid, "R11", "valids", LW'({wo_valid, ro_valid}), 0);
        chk(tbl_count == 0 && !tbl_full, "R11", "count", LW'(tbl_count), 0);
        rst_n = 1'b1;

        do_read("R6", 8'd200, mk(1, 3));                 // untracked passes
        do_write("R1", 8'd9, mk(0, 1), 1'b0);            // clean write unchanged
        do_write("R2", 8'd10, mk(1, 2), 1'b1);           // compressed, marker tail
        do_write("R2", 8'd11, mk(2, 2), 1'b1);

        // R3 / R7: fill every entry, alternating markers
        for (int i = 0; i < DP; i++)
            do_write(i == DP - 1 ? "R7" : "R3", AW'(i * 3 + 1), mk(1 + (i % 2), i), 1'b0);

        // R6: readback of every tracked address restores
        for (int i = 0; i < DP; i++)
            do_read("R6", AW'(i * 3 + 1), ~mk(1 + (i % 2), i));
        do_read("R6", 8'd2, mk(0, 7));

        // R8: collision with full table
        do_write("R8", 8'd100, mk(2, 9), 1'b0);
        do_read("R8", 8'd100, ~mk(2, 9));

        // R4: colliding rewrite of tracked address
        do_write("R4", 8'd1, mk(2, 5), 1'b0);

        // R10: write releasing addr 4 and read of addr 4 in one cycle
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 8'd4; wr_data = mk(0, 4); wr_comp = 1'b0;
        rd_valid = 1'b1; rd_addr = 8'd4; rd_data = 64'h0123_4567_89AB_CDEF;
        chk(tracked[4], "R10", "model", 0, 1);
        model_write(8'd4, mk(0, 4), 1'b0, ed, esp);
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0; rd_valid = 1'b0;
        chk(ro_flip == 1'b1, "R10", "ro_flip", LW'(ro_flip), 1);
        chk(ro_data == ~64'h0123_4567_89AB_CDEF, "R10", "ro_data", ro_data, ~64'h0123_4567_89AB_CDEF);
        chk(int'(tbl_count) == cnt, "R5", "tbl_count", LW'(tbl_count), LW'(cnt));
        do_read("R5", 8'd4, mk(0, 4));

        // R5: compressed write releases
        do_write("R5", 8'd7, mk(1, 6), 1'b1);
        do_read("R5", 8'd7, mk(1, 6));

        // R3: now a free slot exists
        do_write("R3", 8'd100, mk(1, 9), 1'b0);
        do_read("R3", 8'd100, ~mk(1, 9));

        // R9: back-pressure on the write output
        da = mk(0, 20); db = mk(0, 21);
        @(negedge clk);
        wo_ready = 1'b0;
        wr_valid = 1'b1; wr_addr = 8'd60; wr_data = da; wr_comp = 1'b0;
        @(posedge clk);
        @(negedge clk);
        wr_addr = 8'd61; wr_data = db;
        chk(wr_ready == 1'b0, "R9", "wr_ready", LW'(wr_ready), 0);
        repeat (2) @(negedge clk);
        chk(wo_valid && wo_data == da, "R9", "held data", wo_data, da);
        wo_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        chk(wo_valid && wo_data == db && wo_addr == 8'd61, "R9", "next data", wo_data, db);
        @(negedge clk);
        chk(!wo_valid, "R9", "drained", LW'(wo_valid), 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule